// File: doc/BRIEF.md
# Grayscale LCD Pixel Unpacker with Palette

This block sits between display memory and an LCD timing generator. Display memory arrives as 32-bit words on a fill port, and a DMA engine outside the block feeds that port. The words go into a small prefetch FIFO. An unpacker pulls words from the FIFO and splits them into pixels of 1, 2 or 4 bits. Pixel 0 of a word is taken from its least significant bits.

Each pixel value indexes a 16-entry table of 4-bit physical gray codes. The resulting code leaves the block with two markers: one for the last pixel of a line and one for the first pixel of a frame. Line length and line count are programmable. The block raises a refill request while the FIFO runs low. An empty FIFO at the moment a pixel is due yields gray 0 and latches a sticky underflow flag.

Software programs three registers through a simple write port: two palette words and one control word. The timing side paces output with a per-pixel tick.

Top module: `lcd_pix_unpack`

## Requirements
- R1: Control register (address 2) bits [1:0] select the pixel depth: 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, and 3 behaves as 4 bits.
- R2: Within a word, pixels are consumed from the least significant bits upward. The first pixel uses bits [b-1:0], the next uses [2b-1:b], and so on.
- R3: Palette entry n is held in bits [4n+3:4n]. Entries 0–7 are in the register at address 0 and entries 8–15 in the register at address 1. The output gray code is the entry selected by the pixel value.
- R4: A 1-bit or 2-bit pixel value indexes the palette directly, so only entries 0–1 or 0–3 are reachable.
- R5: Control bits [7:2] hold k, and a line is (k+1)×16 pixels long. line_end_o is high together with the last pixel of every line.
- R6: Control bits [15:8] hold m, and a frame is m+1 lines. frame_start_o is high with the first pixel of each frame. The pixel after the last pixel of a frame always comes from a fresh word, and any pixels left in the current word are dropped.
- R7: The FIFO holds 9 words. A fill write while it is full is ignored.
- R8: dma_req_o is high whenever the FIFO holds 4 or fewer words. It is low whenever the FIFO is full, and it holds its value at levels in between.
- R9: A pixel that is due while a new word is needed and the FIFO is empty outputs gray 0, consumes no data, and sets underflow_o. underflow_o stays set until the next control write.
- R10: Control bit 16 enables output. While it is clear, ticks produce no pixels, and the line, frame and in-word positions return to their start.
- R11: A tick with output enabled produces exactly one pixel on the following cycle, marked by pix_valid_o.
- R12: After reset, dma_req_o is high, pix_valid_o and underflow_o are low, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 palette low, 1 palette high, 2 control |
| reg_wdata_i | input | 32 | Register write data |
| fill_valid_i | input | 1 | Display word write into FIFO |
| fill_data_i | input | 32 | Display word |
| dma_req_o | output | 1 | FIFO refill request |
| pix_tick_i | input | 1 | One pixel is due |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_gray_o | output | 4 | Physical gray code |
| line_end_o | output | 1 | Last pixel of a line |
| frame_start_o | output | 1 | First pixel of a frame |
| underflow_o | output | 1 | Sticky FIFO underflow flag |

## Verification
The bench builds the block with its default 9-word FIFO and low mark of 4. These defaults make the hysteresis band of the refill request (levels 5 to 8) and a rejected tenth fill directly observable. It programs short lines of 16 and 32 pixels with one or two lines per frame. That brings frame wrap within reach of a few words, and at 1 bit per pixel it produces a frame that ends mid-word, which exercises the discarded word tail. Draining the FIFO past empty reaches the underflow path and shows that no stray word was accepted.

// File: rtl/lcd_pix_pkg.sv
package lcd_pix_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned GRAY_W    = 4;
  localparam int unsigned PAL_N     = 16;
  localparam int unsigned PAL_W     = PAL_N * GRAY_W;
  localparam int unsigned LEN_W     = 6;   // line length in 16-pixel units
  localparam int unsigned LINES_W   = 8;
  localparam int unsigned COL_W     = LEN_W + 4;
  localparam int unsigned SLOT_W    = $clog2(WORD_W);

  localparam logic [1:0] ADDR_PAL_LO = 2'd0;
  localparam logic [1:0] ADDR_PAL_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  typedef enum logic [1:0] {
    DEPTH_1 = 2'd0,
    DEPTH_2 = 2'd1,
    DEPTH_4 = 2'd2,
    DEPTH_4X = 2'd3
  } depth_e;

  typedef struct packed {
    logic               en;
    logic [LINES_W-1:0] lines_m1;
    logic [LEN_W-1:0]   len_m1;
    depth_e             depth;
  } ctrl_t;
endpackage

// File: rtl/lcd_pix_regs.sv
module lcd_pix_regs
  import lcd_pix_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [PAL_W-1:0]  pal_o,
  output ctrl_t             ctrl_o,
  output logic              ctrl_wr_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  assign ctrl_wr_o = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pal_o  <= '0;
      ctrl_o <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_PAL_LO: pal_o[WORD_W-1:0]     <= wdata_i;
        ADDR_PAL_HI: pal_o[PAL_W-1:WORD_W] <= wdata_i;
        ADDR_CTRL:   ctrl_o                <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcd_pix_fifo.sv
module lcd_pix_fifo #(
  parameter int unsigned DEPTH    = 9,
  parameter int unsigned LOW_MARK = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              req_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_LOW  = LVL_W'(LOW_MARK);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              full, do_push, do_pop, req_q;

  assign full    = (lvl_q == LVL_FULL);
  assign empty_o = (lvl_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  always_comb begin
    lvl_d = lvl_q;
    if (do_push && !do_pop) lvl_d = lvl_q + 1'b1;
    else if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      req_q <= 1'b1;
    end else begin
      lvl_q <= lvl_d;
      if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (lvl_d <= LVL_LOW)       req_q <= 1'b1;
      else if (lvl_d == LVL_FULL) req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  assign req_o = req_q;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_FULL);
  p_full_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> (lvl_q == LVL_FULL));
  p_req_low_mark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q <= LVL_LOW) |-> req_o);
  p_req_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !req_o);
endmodule

// File: rtl/lcd_pix_timing.sv
module lcd_pix_timing
  import lcd_pix_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               step_i,
  input  logic [LEN_W-1:0]   len_m1_i,
  input  logic [LINES_W-1:0] lines_m1_i,
  output logic               first_o,
  output logic               line_last_o,
  output logic               frame_last_o
);
  logic [COL_W-1:0]   col_q;
  logic [LINES_W-1:0] row_q;

  assign line_last_o  = (col_q == {len_m1_i, 4'hF});
  assign frame_last_o = line_last_o && (row_q == lines_m1_i);
  assign first_o      = (col_q == '0) && (row_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (clr_i) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step_i) begin
      if (line_last_o) begin
        col_q <= '0;
        row_q <= frame_last_o ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  p_line_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && line_last_o) |=> (col_q == '0));
  p_frame_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && frame_last_o) |=> first_o);
endmodule

// File: rtl/lcd_pix_unpack.sv
module lcd_pix_unpack
  import lcd_pix_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 9,
  parameter int unsigned LOW_MARK   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              fill_valid_i,
  input  logic [WORD_W-1:0] fill_data_i,
  output logic              dma_req_o,
  input  logic              pix_tick_i,
  output logic              pix_valid_o,
  output logic [GRAY_W-1:0] pix_gray_o,
  output logic              line_end_o,
  output logic              frame_start_o,
  output logic              underflow_o
);
  logic [PAL_W-1:0]  pal;
  ctrl_t             ctrl;
  logic              ctrl_wr;
  logic [WORD_W-1:0] head, src, word_q;
  logic              fifo_empty, pop, under, due, need_word;
  logic              first, line_last, frame_last;
  logic [SLOT_W-1:0] slot_q, slot_last;
  logic [2:0]        bits;
  logic [3:0]        idx;

  lcd_pix_regs u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .pal_o     (pal),
    .ctrl_o    (ctrl),
    .ctrl_wr_o (ctrl_wr)
  );

  lcd_pix_fifo #(.DEPTH(FIFO_DEPTH), .LOW_MARK(LOW_MARK), .DATA_W(WORD_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i      (fill_valid_i),
    .push_data_i (fill_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (fifo_empty),
    .req_o       (dma_req_o)
  );

  lcd_pix_timing u_tim (
    .clk_i, .rst_ni,
    .clr_i        (!ctrl.en),
    .step_i       (due),
    .len_m1_i     (ctrl.len_m1),
    .lines_m1_i   (ctrl.lines_m1),
    .first_o      (first),
    .line_last_o  (line_last),
    .frame_last_o (frame_last)
  );

  always_comb begin
    unique case (ctrl.depth)
      DEPTH_1: begin bits = 3'd1; slot_last = SLOT_W'(WORD_W - 1);     end
      DEPTH_2: begin bits = 3'd2; slot_last = SLOT_W'(WORD_W / 2 - 1); end
      default: begin bits = 3'd4; slot_last = SLOT_W'(WORD_W / 4 - 1); end
    endcase
  end

  assign due       = ctrl.en && pix_tick_i;
  assign need_word = (slot_q == '0);
  assign pop       = due && need_word && !fifo_empty;
  assign under     = due && need_word && fifo_empty;
  assign src       = need_word ? head : word_q;

  always_comb begin
    unique case (bits)
      3'd1:    idx = {3'b000, src[0]};
      3'd2:    idx = {2'b00, src[1:0]};
      default: idx = src[3:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      word_q <= '0;
    end else if (!ctrl.en) begin
      slot_q <= '0;
    end else if (due) begin
      word_q <= src >> bits;
      if (frame_last || under || slot_q == slot_last) slot_q <= '0;
      else slot_q <= slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o   <= 1'b0;
      pix_gray_o    <= '0;
      line_end_o    <= 1'b0;
      frame_start_o <= 1'b0;
      underflow_o   <= 1'b0;
    end else begin
      pix_valid_o   <= due;
      line_end_o    <= due && line_last;
      frame_start_o <= due && first;
      if (due) pix_gray_o <= under ? '0 : pal[{idx, 2'b00} +: GRAY_W];
      if (under) underflow_o <= 1'b1;
      else if (ctrl_wr) underflow_o <= 1'b0;
    end
  end

  p_under_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    under |=> (pix_valid_o && pix_gray_o == '0 && underflow_o));
  p_under_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !ctrl_wr) |=> underflow_o);
  p_idle_no_pix_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |=> !pix_valid_o);
  p_one_pix_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due |=> pix_valid_o);
  p_marks_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_end_o || frame_start_o) |-> pix_valid_o);
endmodule

// File: tb/lcd_pix_unpack_tb.sv
module lcd_pix_unpack_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        fill_valid_i = 1'b0;
  logic [31:0] fill_data_i = '0;
  logic        dma_req_o;
  logic        pix_tick_i = 1'b0;
  logic        pix_valid_o;
  logic [3:0]  pix_gray_o;
  logic        line_end_o;
  logic        frame_start_o;
  logic        underflow_o;

  always #5 clk_i = ~clk_i;

  lcd_pix_unpack u_dut (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [63:0] m_pal;
  logic [31:0] m_fifo[$];
  logic [31:0] m_cur;
  int m_bits = 1, m_len = 16, m_lines = 1, m_slot = 0, m_col = 0, m_row = 0;
  bit m_en = 0;
  logic [5:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R2";
  int idle_pix = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a == 2'd0) m_pal[31:0] = d;
    if (a == 2'd1) m_pal[63:32] = d;
    if (a == 2'd2) begin
      m_bits  = (d[1:0] == 2'd0) ? 1 : (d[1:0] == 2'd1) ? 2 : 4;
      m_len   = (int'(d[7:2]) + 1) * 16;
      m_lines = int'(d[15:8]) + 1;
      m_en    = d[16];
      if (!m_en) begin m_slot = 0; m_col = 0; m_row = 0; end
    end
  endtask

  task automatic write_ctrl(int depth, int len_m1, int lines_m1, bit en);
    write_reg(2'd2, {15'd0, en, 8'(lines_m1), 6'(len_m1), 2'(depth)});
  endtask

  task automatic push_words(int n, int seed);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = (32'(seed + i) * 32'h9E3779B1) ^ 32'h5A3C_96E1;
      @(negedge clk_i);
      fill_valid_i = 1'b1; fill_data_i = w;
      if (m_fifo.size() < 9) m_fifo.push_back(w);
    end
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic model_step();
    logic [3:0] v, g;
    bit und, le, fs;
    und = 0;
    if (m_slot == 0) begin
      if (m_fifo.size() == 0) und = 1;
      else m_cur = m_fifo.pop_front();
    end
    v = (m_bits == 1) ? {3'b0, m_cur[0]} : (m_bits == 2) ? {2'b0, m_cur[1:0]} : m_cur[3:0];
    g = und ? 4'h0 : m_pal[v*4 +: 4];
    if (!und) m_cur = m_cur >> m_bits;
    fs = (m_col == 0 && m_row == 0);
    le = (m_col == m_len - 1);
    exp_q.push_back({le, fs, g});
    tag_q.push_back(cur_tag);
    if (le) begin
      m_col = 0;
      if (m_row == m_lines - 1) begin m_row = 0; m_slot = 0; end
      else begin
        m_row++;
        if (!und) m_slot = (m_slot + 1) % (32 / m_bits);
      end
    end else begin
      m_col++;
      if (!und) m_slot = (m_slot + 1) % (32 / m_bits);
    end
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      pix_tick_i = 1'b1;
      if (m_en) model_step();
    end
    @(negedge clk_i);
    pix_tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  // monitor: scoreboard compare
  always @(negedge clk_i) begin
    if (rst_ni && pix_valid_o) begin
      if (exp_q.size() == 0) begin
        idle_pix++;
        check(1'b0, "R10 unexpected pixel", 1, 0);
      end else begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({line_end_o, frame_start_o, pix_gray_o} == e, t,
              int'({line_end_o, frame_start_o, pix_gray_o}), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    m_pal = '0;
    m_cur = '0;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check(dma_req_o == 1'b1, "R12 dma_req", int'(dma_req_o), 1);
    check(pix_valid_o == 1'b0, "R12 pix_valid", int'(pix_valid_o), 0);
    check(underflow_o == 1'b0, "R12 underflow", int'(underflow_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(dma_req_o == 1'b1, "R12 dma_req after release", int'(dma_req_o), 1);

    // R3 palette: entry n = 15-n
    write_reg(2'd0, 32'h89AB_CDEF);
    write_reg(2'd1, 32'h0123_4567);
    write_ctrl(2, 0, 1, 1);

    // R7: tenth word must be dropped
    push_words(10, 1);
    check(dma_req_o == 1'b0, "R8 full drops request", int'(dma_req_o), 0);

    cur_tag = "R3 R5 R6 4bpp frame";
    run_ticks(32);
    check(dma_req_o == 1'b0, "R8 level 5 holds low", int'(dma_req_o), 0);
    run_ticks(8);
    check(dma_req_o == 1'b1, "R8 level 4 requests", int'(dma_req_o), 1);

    cur_tag = "R7 drain";
    run_ticks(32);
    cur_tag = "R9 underflow gray 0";
    run_ticks(8);
    check(underflow_o == 1'b1, "R9 underflow set", int'(underflow_o), 1);
    repeat (5) @(negedge clk_i);
    check(underflow_o == 1'b1, "R9 underflow sticky", int'(underflow_o), 1);

    // R10 disabled
    write_ctrl(2, 0, 1, 0);
    check(underflow_o == 1'b0, "R9 cleared by control write", int'(underflow_o), 0);
    push_words(2, 40);
    idle_pix = 0;
    run_ticks(6);
    check(idle_pix == 0, "R10 no pixels when disabled", idle_pix, 0);
    check(underflow_o == 1'b0, "R10 no underflow when disabled", int'(underflow_o), 0);

    // R1 R4 2bpp, 32-pixel single-line frame
    write_ctrl(1, 1, 0, 1);
    push_words(7, 100);
    cur_tag = "R1 R4 2bpp";
    run_ticks(64);

    // R6 1bpp frame of 16 pixels ends mid-word
    write_ctrl(0, 0, 0, 0);
    write_ctrl(0, 0, 0, 1);
    cur_tag = "R6 R4 1bpp mid-word frame";
    run_ticks(48);

    // R1 depth code 3 acts as 4bpp
    write_ctrl(3, 0, 0, 0);
    write_ctrl(3, 0, 0, 1);
    push_words(4, 300);
    cur_tag = "R1 depth code 3";
    run_ticks(20);

    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R11 every tick produced a pixel", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule